// File: doc/BRIEF.md
# Descriptor Address Queue Manager

This block keeps a bank of independent first-in first-out queues whose entries are 32-bit descriptor addresses. Software and firmware reach every queue through one 32-bit register window. A write to a queue's data word appends an address to that queue, and a read of the same word removes the oldest address and returns it. A second window returns a queue's head entry without removing it. A third window returns a queue's fill level together with a sticky overflow flag. A single flush register takes a queue index as its write data and empties that queue.

All queues share one storage array that is split into fixed, equal partitions. A read pointer, a write pointer and a fill count are kept for each queue. Read data is registered. It appears on the bus one cycle after the request, with a strobe. The descriptor memory the addresses point to, and whatever consumes the queues, sit outside this block.

Top module: `dqm_top`

## Requirements
- R1: A write to byte offset 0xD00 + 4*q (q = 0..63) appends the write data to queue q. A read of that same offset removes the oldest entry of queue q and returns it, so entries leave in the order they were written.
- R2: A read of a queue's data word while that queue is empty returns 0xFFFFFFFF and leaves the queue unchanged.
- R3: Each queue holds 16 entries. A write to a full queue is discarded and sets that queue's overflow flag. The flag stays set until the queue is flushed, and the 16 entries already held are kept intact and in order.
- R4: A read of offset 0xE00 + 4*q, for q = 0..15 only, returns the head entry of queue q without removing it. If the queue is empty, the read returns 0xFFFFFFFF.
- R5: A read of offset 0xE40 + 4*q (q = 0..63) returns the status word of queue q. Bits 4:0 hold the fill count (0..16), bit 8 holds the overflow flag, and all other bits read as zero.
- R6: A write of value v to offset 0xF40 empties queue v and clears its overflow flag when v < 64. Any value of 64 or above is ignored.
- R7: An operation on one queue never changes the contents, count or flag of any other queue.
- R8: Writes to the head-view window and the status window have no effect. A read of an offset that maps to nothing returns zero. Offsets that are not word aligned count as unmapped.
- R9: After reset, every queue is empty with its overflow flag clear, and the read strobe is low.
- R10: The read strobe is high in exactly the cycle after a read request, and is never raised by a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data strobe |

## Verification
Every queue update (append, removal, flag set, flush) happens at the clock edge that samples the request. The read word and its strobe are registered at that same edge, so both are due one cycle after the request. The bench drives each request on a falling edge and samples bus_rdata and bus_rvalid on the next falling edge, half a cycle after the edge that produced them. Effects of writes are checked through a later status or data read rather than by timing. After every write, the strobe is checked to be low, which confirms that writes produce no read data.

// File: rtl/dqm_pkg.sv
package dqm_pkg;

    // Register window layout (byte offsets)
    localparam int QUEUE_BASE  = 'hD00;
    localparam int PEEK_BASE   = 'hE00;
    localparam int STAT_BASE   = 'hE40;
    localparam int FLUSH_OFS   = 'hF40;

    // Status word layout
    localparam int OVF_BIT     = 8;
    localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_QUEUE,
        ACC_PEEK,
        ACC_STAT,
        ACC_FLUSH
    } dqm_kind_e;

    typedef struct packed {
        logic      vld;
        logic      we;
        dqm_kind_e kind;
    } dqm_acc_t;

    function automatic logic [31:0] dqm_stat_word(input logic [7:0] cnt, input logic ovf);
        logic [31:0] w;
        w = '0;
        w[7:0] = cnt;
        w[OVF_BIT] = ovf;
        return w;
    endfunction

endpackage

// File: rtl/dqm_decode.sv
module dqm_decode
    import dqm_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_Q   = 64,
    parameter int PEEK_Q  = 16,
    parameter int QIDX_W  = $clog2(NUM_Q),
    parameter int Q_BASE  = QUEUE_BASE,
    parameter int P_BASE  = PEEK_BASE,
    parameter int S_BASE  = STAT_BASE,
    parameter int F_ADDR  = FLUSH_OFS
) (
    input  logic [ADDR_W-1:0] addr,
    output dqm_kind_e         kind,
    output logic [QIDX_W-1:0] qidx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] rel;

    assign word = addr[ADDR_W-1:2];

    always_comb begin
        kind = ACC_NONE;
        rel  = '0;
        if (addr[1:0] == 2'b00) begin
            if (int'(addr) >= Q_BASE && int'(addr) < Q_BASE + 4 * NUM_Q) begin
                kind = ACC_QUEUE;
                rel  = word - WORD_W'(Q_BASE / 4);
            end else if (int'(addr) >= P_BASE && int'(addr) < P_BASE + 4 * PEEK_Q) begin
                kind = ACC_PEEK;
                rel  = word - WORD_W'(P_BASE / 4);
            end else if (int'(addr) >= S_BASE && int'(addr) < S_BASE + 4 * NUM_Q) begin
                kind = ACC_STAT;
                rel  = word - WORD_W'(S_BASE / 4);
            end else if (int'(addr) == F_ADDR) begin
                kind = ACC_FLUSH;
            end
        end
    end

    assign qidx = QIDX_W'(rel);

endmodule

// File: rtl/dqm_qstate.sv
module dqm_qstate #(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             push_ok
);
    logic full;
    logic empty;
    logic pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push_ok)
                wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
            if (push && full)
                ovf <= 1'b1;
        end
    end

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R2
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !flush && count == '0) |=> (count == '0 && $stable(rd_ptr)));

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && count == CNT_W'(DEPTH)) |=> (ovf && count == CNT_W'(DEPTH) && $stable(wr_ptr)));

    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && !ovf));

    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !flush) |=> ovf);

endmodule

// File: rtl/dqm_ram.sv
module dqm_ram #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 1024,
    parameter int AW     = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dqm_top.sv
module dqm_top
    import dqm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int NUM_Q  = 64,
    parameter int DEPTH  = 16,
    parameter int PEEK_Q = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    localparam int QIDX_W = $clog2(NUM_Q);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = PTR_W + 1;
    localparam int RAM_AW = QIDX_W + PTR_W;

    dqm_kind_e          kind;
    logic [QIDX_W-1:0]  qsel;
    dqm_acc_t           acc;

    logic [PTR_W-1:0]   q_rd  [NUM_Q];
    logic [PTR_W-1:0]   q_wr  [NUM_Q];
    logic [CNT_W-1:0]   q_cnt [NUM_Q];
    logic [NUM_Q-1:0]   q_ovf;
    logic [NUM_Q-1:0]   q_push;
    logic [NUM_Q-1:0]   q_pop;
    logic [NUM_Q-1:0]   q_flush;
    logic [NUM_Q-1:0]   q_push_ok;

    logic               flush_valid;
    logic [QIDX_W-1:0]  flush_idx;
    logic [DATA_W-1:0]  head_word;
    logic [DATA_W-1:0]  rd_word;
    logic               sel_empty;

    dqm_decode #(
        .ADDR_W (ADDR_W),
        .NUM_Q  (NUM_Q),
        .PEEK_Q (PEEK_Q),
        .QIDX_W (QIDX_W)
    ) u_decode (
        .addr (bus_addr),
        .kind (kind),
        .qidx (qsel)
    );

    assign acc.vld  = bus_req;
    assign acc.we   = bus_we;
    assign acc.kind = kind;

    assign flush_valid = acc.vld && acc.we && acc.kind == ACC_FLUSH
                         && bus_wdata < DATA_W'(NUM_Q);
    assign flush_idx   = QIDX_W'(bus_wdata);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        assign q_push[g]  = acc.vld && acc.we  && acc.kind == ACC_QUEUE && qsel == QIDX_W'(g);
        assign q_pop[g]   = acc.vld && !acc.we && acc.kind == ACC_QUEUE && qsel == QIDX_W'(g);
        assign q_flush[g] = flush_valid && flush_idx == QIDX_W'(g);

        dqm_qstate #(
            .DEPTH (DEPTH),
            .PTR_W (PTR_W),
            .CNT_W (CNT_W)
        ) u_qstate (
            .clk     (clk),
            .rst     (rst),
            .push    (q_push[g]),
            .pop     (q_pop[g]),
            .flush   (q_flush[g]),
            .rd_ptr  (q_rd[g]),
            .wr_ptr  (q_wr[g]),
            .count   (q_cnt[g]),
            .ovf     (q_ovf[g]),
            .push_ok (q_push_ok[g])
        );
    end

    dqm_ram #(
        .DATA_W (DATA_W),
        .WORDS  (NUM_Q * DEPTH),
        .AW     (RAM_AW)
    ) u_ram (
        .clk   (clk),
        .we    (|q_push_ok),
        .waddr ({qsel, q_wr[qsel]}),
        .wdata (bus_wdata),
        .raddr ({qsel, q_rd[qsel]}),
        .rdata (head_word)
    );

    assign sel_empty = (q_cnt[qsel] == '0);

    always_comb begin
        case (acc.kind)
            ACC_QUEUE, ACC_PEEK: rd_word = sel_empty ? EMPTY_WORD : head_word;
            ACC_STAT:            rd_word = dqm_stat_word(8'(q_cnt[qsel]), q_ovf[qsel]);
            default:             rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= acc.vld && !acc.we;
            if (acc.vld && !acc.we)
                bus_rdata <= rd_word;
        end
    end

    // R10
    rvalid_timing_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid == $past(bus_req && !bus_we));

    // R7
    one_push_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_push_ok));

    // R8
    stat_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && kind == ACC_STAT) |=> $stable(q_ovf));

endmodule

// File: tb/dqm_top_tb_top.sv
`timescale 1ns/1ps
module dqm_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_req;
    logic        bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dqm_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    function automatic logic [11:0] qa(input int q);   return 12'(32'hD00 + 4 * q); endfunction
    function automatic logic [11:0] pa(input int q);   return 12'(32'hE00 + 4 * q); endfunction
    function automatic logic [11:0] sa(input int q);   return 12'(32'hE40 + 4 * q); endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        v = bus_rvalid;
    endtask

    task automatic read_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic v;
        bus_read(a, d, v);
        chk({tag, " strobe"}, 32'(v), 32'd1);
        chk(tag, d, exp);
    endtask

    task automatic t_reset;
        chk("R9 strobe low after reset", 32'(bus_rvalid), 32'd0);
        read_chk("R9 queue 0 status", sa(0), 32'h0);
        read_chk("R9 queue 63 status", sa(63), 32'h0);
        read_chk("R9 queue 20 pop empty", qa(20), 32'hFFFF_FFFF);
    endtask

    task automatic t_fifo;
        bus_write(qa(5), 32'hA000_0001);
        bus_write(qa(5), 32'hA000_0002);
        bus_write(qa(5), 32'hA000_0003);
        read_chk("R5 count after three appends", sa(5), 32'h3);
        read_chk("R1 first out", qa(5), 32'hA000_0001);
        read_chk("R1 second out", qa(5), 32'hA000_0002);
        read_chk("R1 third out", qa(5), 32'hA000_0003);
        read_chk("R1 count back to zero", sa(5), 32'h0);
    endtask

    task automatic t_empty;
        read_chk("R2 pop empty queue 7", qa(7), 32'hFFFF_FFFF);
        read_chk("R2 queue 7 unchanged", sa(7), 32'h0);
        bus_write(qa(7), 32'h0000_0777);
        read_chk("R2 queue usable after empty pop", qa(7), 32'h0000_0777);
    endtask

    task automatic t_full;
        for (int i = 0; i < 17; i++)
            bus_write(qa(40), 32'h100 + 32'(i));
        read_chk("R3 full with overflow flag", sa(40), 32'h110);
        read_chk("R3 oldest kept", qa(40), 32'h100);
        read_chk("R3 flag sticky after removal", sa(40), 32'h10F);
        for (int i = 1; i < 15; i++) begin
            logic [31:0] d;
            logic v;
            bus_read(qa(40), d, v);
        end
        read_chk("R3 last held entry, extra append dropped", qa(40), 32'h10F);
        read_chk("R3 drained", qa(40), 32'hFFFF_FFFF);
        read_chk("R5 empty with flag", sa(40), 32'h100);
    endtask

    task automatic t_peek;
        bus_write(qa(3), 32'h0000_00AB);
        read_chk("R4 head view", pa(3), 32'h0000_00AB);
        read_chk("R4 head view again", pa(3), 32'h0000_00AB);
        read_chk("R4 head view keeps count", sa(3), 32'h1);
        read_chk("R4 head view empty", pa(10), 32'hFFFF_FFFF);
        read_chk("R4 entry still removable", qa(3), 32'h0000_00AB);
    endtask

    task automatic t_flush;
        bus_write(qa(0), 32'h11);
        bus_write(qa(0), 32'h12);
        bus_write(qa(1), 32'h21);
        bus_write(12'hF40, 32'd64);
        read_chk("R6 out-of-range flush ignored", sa(0), 32'h2);
        bus_write(12'hF40, 32'd0);
        read_chk("R6 queue 0 flushed", sa(0), 32'h0);
        read_chk("R7 queue 1 untouched", sa(1), 32'h1);
        read_chk("R6 flushed queue pops empty", qa(0), 32'hFFFF_FFFF);
        bus_write(12'hF40, 32'd40);
        read_chk("R6 flush clears flag", sa(40), 32'h0);
    endtask

    task automatic t_ignore;
        bus_write(sa(1), 32'h0000_011F);
        chk("R10 no strobe on write", 32'(bus_rvalid), 32'd0);
        bus_write(pa(1), 32'hDEAD_BEEF);
        read_chk("R8 status write ignored", sa(1), 32'h1);
        read_chk("R8 data intact", qa(1), 32'h21);
        read_chk("R8 unmapped read", 12'h100, 32'h0);
        read_chk("R8 misaligned read", 12'hD01, 32'h0);
        read_chk("R8 gap after flush register", 12'hF44, 32'h0);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fifo();
        t_empty();
        t_full();
        t_peek();
        t_flush();
        t_ignore();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule